// File: doc/BRIEF.md
# Last Branch Recording Debug Unit

This unit sits beside a simple 32-bit processor core and keeps a record of where control flow last jumped. The core presents one control-transfer event per cycle on an event bus: a kind code plus the source and target addresses. While recording is switched on, taken branches, interrupts and ordinary exceptions overwrite a "last transfer" address pair. On any exception, including a debug exception, the pair that was in place just before is copied into a second "last exception" pair. A debug exception never overwrites the last-transfer pair itself. This way a debugger can see how the core arrived at the faulting point.

The unit also holds a 32-bit debug control register. It carries the record enable, a branch single-step flag, a trace-message enable and four pin-mode flags. The single-step and trace flags are only held here and shown on outputs. Each of four active-low pins shows either a one-cycle pulse when its breakpoint comparator fires, or the state of a performance event input. A per-pin mode flag picks which. Software reads and writes the registers through a plain address/data port. Reads are combinational.

Top module: `lbr_debug_unit`

## Requirements
- R1: Control register (address 0) bits: bit 0 record enable, bit 1 single-step on branches, bits 2..5 pin mode for pins 0..3, bit 6 trace-message enable. The outputs `stepOnBranch` and `traceEnable` show bits 1 and 6.
- R2: Every register resets to zero. Control bits 31..7 ignore writes and always read as zero.
- R3: A recorded event of kind 1 (taken branch) loads `evtFrom` into the last-from register (address 1) and `evtTo` into the last-to register (address 2). The new values are readable in the next cycle.
- R4: Recorded events of kind 2 (interrupt) and kind 3 (exception) load the last-from and last-to registers in the same way as a branch.
- R5: An event of kind 4 (debug exception) leaves the last-from and last-to registers unchanged.
- R6: Events of kind 3 and kind 4 copy the last-from and last-to values from before the event into the exception-from register (address 3) and the exception-to register (address 4).
- R7: While record enable is 0, no event changes any of the four address registers. Kind 0 is never recorded.
- R8: While trace enable is 1, all four address registers are forced to the poison value 32'hBAD0_BAD0, and no event is recorded. Their contents count as undefined until trace enable is cleared. After that they keep the poison value until the next capture.
- R9: When pin mode i is 1, a rising edge on `bpMatch[i]` drives `bpPinN[i]` low for exactly one cycle, starting in the cycle after the edge. A match held high gives only one pulse.
- R10: When pin mode i is 0, `bpPinN[i]` is the inverse of `perfEvt[i]` in the same cycle.
- R11: When a control register write and an event happen in the same cycle, the event is judged by the control value from before the write.
- R12: Writes to addresses 1..7 have no effect. Reads of addresses 5..7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Event present this cycle |
| evtKind | input | 3 | 0 none, 1 branch, 2 interrupt, 3 exception, 4 debug exception |
| evtFrom | input | 32 | Source address of the transfer |
| evtTo | input | 32 | Target or handler address |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` |
| bpMatch | input | 4 | Breakpoint comparator hits, one per pin |
| perfEvt | input | 4 | Performance event levels, one per pin |
| bpPinN | output | 4 | Active-low breakpoint/performance pins |
| stepOnBranch | output | 1 | Single-step-on-branches flag |
| traceEnable | output | 1 | Trace-message enable flag |

## Verification
The embedded assertions check several rules on every cycle. Reserved control bits stay zero. A branch-pin pulse never lasts longer than one cycle. The exception pair receives the last-transfer pair from before the event. Nothing moves while recording is off. Trace mode forces the poison value. A debug exception leaves the visible last-from value alone. Other behaviour can only be shown by the bench's scenarios, which compare the read port and pins against a behavioural model on every clock. These include the full kind decoding across interrupts and exceptions, and the use of the old control value when a write meets an event. They also cover the edge-only pulse for a held match, the pass-through of performance events, and the ignored writes and zero reads of other addresses.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

  typedef enum logic [2:0] {
    EV_NONE   = 3'd0,
    EV_BRANCH = 3'd1,
    EV_INTR   = 3'd2,
    EV_EXC    = 3'd3,
    EV_DBG    = 3'd4
  } evKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLast;
    logic snapExc;
    logic poison;
  } dpStrobe_t;

  localparam int REC_BIT  = 0;
  localparam int STEP_BIT = 1;
  localparam int MODE_LSB = 2;

  localparam logic [2:0] A_CTRL     = 3'd0;
  localparam logic [2:0] A_LASTFROM = 3'd1;
  localparam logic [2:0] A_LASTTO   = 3'd2;
  localparam logic [2:0] A_EXCFROM  = 3'd3;
  localparam logic [2:0] A_EXCTO    = 3'd4;

endpackage

// File: rtl/lbr_ctrl.sv
module lbr_ctrl
  import lbr_pkg::*;
#(
  parameter int CTRL_W = 32,
  parameter int NPINS  = 4,
  parameter int RA_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic [2:0]        evtKind,
  input  logic              regWrEn,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [CTRL_W-1:0] regWrData,
  input  logic [NPINS-1:0]  bpMatch,
  input  logic [NPINS-1:0]  perfEvt,
  output logic [CTRL_W-1:0] ctrlReg,
  output dpStrobe_t         strobe,
  output logic [NPINS-1:0]  bpPinN,
  output logic              stepOnBranch,
  output logic              traceEnable
);

  localparam int TRACE_BIT = MODE_LSB + NPINS;
  localparam int LIVE_BITS = TRACE_BIT + 1;
  localparam logic [CTRL_W-1:0] WR_MASK = CTRL_W'((1 << LIVE_BITS) - 1);

  logic [NPINS-1:0] matchQ;
  logic [NPINS-1:0] pulseQ;
  logic             recActive;
  evKind_t          kind;

  assign kind = evKind_t'(evtKind);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      matchQ  <= '0;
      pulseQ  <= '0;
    end else begin
      if (regWrEn && regAddr == RA_W'(A_CTRL))
        ctrlReg <= regWrData & WR_MASK;
      matchQ <= bpMatch;
      pulseQ <= bpMatch & ~matchQ;
    end
  end

  always_comb begin
    strobe.poison   = ctrlReg[TRACE_BIT];
    recActive       = evtValid && ctrlReg[REC_BIT] && !ctrlReg[TRACE_BIT];
    strobe.loadLast = recActive &&
                      (kind == EV_BRANCH || kind == EV_INTR || kind == EV_EXC);
    strobe.snapExc  = recActive && (kind == EV_EXC || kind == EV_DBG);
  end

  assign stepOnBranch = ctrlReg[STEP_BIT];
  assign traceEnable  = ctrlReg[TRACE_BIT];

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign bpPinN[i] = ctrlReg[MODE_LSB+i] ? ~pulseQ[i] : ~perfEvt[i];

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlReg[MODE_LSB+i] && !bpPinN[i]) |=> (!ctrlReg[MODE_LSB+i] || bpPinN[i])); // R9
  end

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[CTRL_W-1:LIVE_BITS] == '0); // R2

endmodule

// File: rtl/lbr_datapath.sv
module lbr_datapath
  import lbr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CTRL_W = 32,
  parameter int RA_W   = 3,
  parameter logic [ADDR_W-1:0] POISON = 32'hBAD0_BAD0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] evtFrom,
  input  logic [ADDR_W-1:0] evtTo,
  input  logic [CTRL_W-1:0] ctrlReg,
  input  logic [RA_W-1:0]   regAddr,
  output logic [ADDR_W-1:0] rdData
);

  localparam int RD_W = (ADDR_W > CTRL_W) ? ADDR_W : CTRL_W;

  logic [ADDR_W-1:0] lastFrom, lastTo, excFrom, excTo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastFrom <= '0;
      lastTo   <= '0;
      excFrom  <= '0;
      excTo    <= '0;
    end else if (strobe.poison) begin
      lastFrom <= POISON;
      lastTo   <= POISON;
      excFrom  <= POISON;
      excTo    <= POISON;
    end else begin
      if (strobe.snapExc) begin
        excFrom <= lastFrom;
        excTo   <= lastTo;
      end
      if (strobe.loadLast) begin
        lastFrom <= evtFrom;
        lastTo   <= evtTo;
      end
    end
  end

  logic [RD_W-1:0] rdMux;
  always_comb begin
    unique case (regAddr)
      RA_W'(A_CTRL):     rdMux = RD_W'(ctrlReg);
      RA_W'(A_LASTFROM): rdMux = RD_W'(lastFrom);
      RA_W'(A_LASTTO):   rdMux = RD_W'(lastTo);
      RA_W'(A_EXCFROM):  rdMux = RD_W'(excFrom);
      RA_W'(A_EXCTO):    rdMux = RD_W'(excTo);
      default:           rdMux = '0;
    endcase
  end
  assign rdData = rdMux[ADDR_W-1:0];

  AST_SNAP_PRIOR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.snapExc |=> (excFrom == $past(lastFrom) && excTo == $past(lastTo))); // R6

  AST_LOAD_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLast |=> (lastFrom == $past(evtFrom) && lastTo == $past(evtTo))); // R3

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[REC_BIT] && !strobe.poison) |=>
      ($stable(lastFrom) && $stable(lastTo) && $stable(excFrom) && $stable(excTo))); // R7

  AST_POISON_FORCED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.poison |=> (lastFrom == POISON && excTo == POISON)); // R8

endmodule

// File: rtl/lbr_debug_unit.sv
module lbr_debug_unit
  import lbr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NPINS  = 4,
  parameter int RA_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic [2:0]        evtKind,
  input  logic [ADDR_W-1:0] evtFrom,
  input  logic [ADDR_W-1:0] evtTo,
  input  logic              regWrEn,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic [NPINS-1:0]  bpMatch,
  input  logic [NPINS-1:0]  perfEvt,
  output logic [NPINS-1:0]  bpPinN,
  output logic              stepOnBranch,
  output logic              traceEnable
);

  localparam int CTRL_W = ADDR_W;

  logic [CTRL_W-1:0] ctrlReg;
  dpStrobe_t         strobe;

  lbr_ctrl #(.CTRL_W(CTRL_W), .NPINS(NPINS), .RA_W(RA_W)) i_ctrl (
    .clk, .rstN, .evtValid, .evtKind, .regWrEn, .regAddr, .regWrData,
    .bpMatch, .perfEvt, .ctrlReg, .strobe, .bpPinN, .stepOnBranch, .traceEnable
  );

  lbr_datapath #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .RA_W(RA_W)) i_dp (
    .clk, .rstN, .strobe, .evtFrom, .evtTo, .ctrlReg, .regAddr,
    .rdData(regRdData)
  );

  AST_DEBUG_KEEPS_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtKind == EV_DBG && !traceEnable && regAddr == RA_W'(A_LASTFROM))
      |=> (regAddr != RA_W'(A_LASTFROM) || regRdData == $past(regRdData))); // R5

endmodule

// File: tb/test_lbr_debug_unit.sv
module test_lbr_debug_unit;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] POISON = 32'hBAD0_BAD0;

  logic        clk = 0;
  logic        rstN;
  logic        evtValid;
  logic [2:0]  evtKind;
  logic [31:0] evtFrom, evtTo;
  logic        regWrEn;
  logic [2:0]  regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic [3:0]  bpMatch, perfEvt, bpPinN;
  logic        stepOnBranch, traceEnable;

  int nChecks = 0;
  int nErrors = 0;

  // behavioural reference state
  logic [31:0] mCtrl;
  logic [31:0] mRegs[5];
  logic [3:0]  mPrevMatch, mPulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbr_debug_unit i_lbr_debug_unit (
    .clk, .rstN, .evtValid, .evtKind, .evtFrom, .evtTo, .regWrEn, .regAddr,
    .regWrData, .regRdData, .bpMatch, .perfEvt, .bpPinN, .stepOnBranch, .traceEnable
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(logic [2:0] a);
    if (a == 3'd0) return mCtrl;
    if (a <= 3'd4) return mRegs[a];
    return 32'h0;
  endfunction

  function automatic logic [3:0] expPins();
    logic [3:0] p;
    for (int i = 0; i < 4; i++)
      p[i] = mCtrl[2+i] ? ~mPulse[i] : ~perfEvt[i];
    return p;
  endfunction

  task automatic modelClock();
    logic [31:0] oldLF, oldLT;
    if (!rstN) begin
      mCtrl = 0; mPrevMatch = 0; mPulse = 0;
      for (int i = 0; i < 5; i++) mRegs[i] = 0;
      return;
    end
    oldLF = mRegs[1]; oldLT = mRegs[2];
    if (mCtrl[6]) begin
      for (int i = 1; i < 5; i++) mRegs[i] = POISON;
    end else if (evtValid && mCtrl[0]) begin
      if (evtKind == 3 || evtKind == 4) begin
        mRegs[3] = oldLF; mRegs[4] = oldLT;
      end
      if (evtKind >= 1 && evtKind <= 3) begin
        mRegs[1] = evtFrom; mRegs[2] = evtTo;
      end
    end
    mPulse = bpMatch & ~mPrevMatch;
    mPrevMatch = bpMatch;
    if (regWrEn && regAddr == 0) mCtrl = regWrData & 32'h7F;
  endtask

  // inputs are set at a falling edge before calling
  task automatic cyc(string tag);
    #1;
    if (!(mCtrl[6] && regAddr >= 1 && regAddr <= 4))
      chk({tag, " rd"}, regRdData, expRead(regAddr));
    chk({tag, " pins"}, {28'h0, bpPinN}, {28'h0, expPins()});
    chk({tag, " R1 flags"}, {30'h0, stepOnBranch, traceEnable},
        {30'h0, mCtrl[1], mCtrl[6]});
    @(posedge clk);
    modelClock();
    @(negedge clk);
    evtValid = 0;
    regWrEn  = 0;
  endtask

  task automatic readAll(string tag);
    for (int a = 0; a < 8; a++) begin
      regAddr = 3'(a);
      cyc(tag);
    end
  endtask

  task automatic wrCtrl(logic [31:0] v, string tag);
    regWrEn = 1; regAddr = 0; regWrData = v;
    cyc(tag);
  endtask

  task automatic event_(logic [2:0] k, logic [31:0] f, logic [31:0] t, string tag);
    evtValid = 1; evtKind = k; evtFrom = f; evtTo = t;
    cyc(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    rstN = 0; evtValid = 0; evtKind = 0; evtFrom = 0; evtTo = 0;
    regWrEn = 0; regAddr = 0; regWrData = 0; bpMatch = 0; perfEvt = 0;
    mCtrl = 0; mPrevMatch = 0; mPulse = 0;
    for (int i = 0; i < 5; i++) mRegs[i] = 0;
    @(negedge clk);
    cyc("R2 reset");
    cyc("R2 reset");
    rstN = 1;
    readAll("R2 reset values");

    // R2: reserved bits dropped
    wrCtrl(32'hFFFF_FF80, "R2 reserved write");
    readAll("R2 reserved zero");
    // R1: bit layout
    wrCtrl(32'h0000_0042, "R1 step+trace");
    wrCtrl(32'h0000_0000, "R1 clear");

    // R7: recording off
    event_(3'd1, 32'h1000, 32'h2000, "R7 branch while off");
    readAll("R7 nothing captured");

    wrCtrl(32'h1, "R1 record on");
    event_(3'd1, 32'h0000_1100, 32'h0000_2200, "R3 branch");
    readAll("R3 branch captured");
    event_(3'd2, 32'h0000_3300, 32'h0000_4400, "R4 interrupt");
    readAll("R4 interrupt captured");
    event_(3'd3, 32'hA000_0010, 32'hF000_0000, "R4 R6 exception");
    readAll("R4 R6 exception captured");
    event_(3'd1, 32'h5555_0000, 32'h6666_0000, "R3 branch again");
    event_(3'd4, 32'h7777_0000, 32'h8888_0000, "R5 debug exception");
    readAll("R5 R6 debug exception");
    event_(3'd0, 32'h9999_0000, 32'h9999_1111, "R7 kind none");
    readAll("R7 kind none ignored");

    // R11: write and event together
    regWrEn = 1; regAddr = 0; regWrData = 32'h0;
    event_(3'd1, 32'hC0DE_0001, 32'hC0DE_0002, "R11 disable with branch");
    readAll("R11 old enable used");
    regWrEn = 1; regAddr = 0; regWrData = 32'h1;
    event_(3'd1, 32'hD00D_0001, 32'hD00D_0002, "R11 enable with branch");
    readAll("R11 old disable used");

    // R12: writes to other addresses ignored
    for (int a = 1; a < 8; a++) begin
      regWrEn = 1; regAddr = 3'(a); regWrData = 32'hFFFF_FFFF;
      cyc("R12 write ignored");
    end
    readAll("R12 after stray writes");

    // R9 R10: pins, modes 0 and 2 on
    wrCtrl(32'h15, "R9 pin modes");
    perfEvt = 4'b1010; cyc("R10 perf pass");
    perfEvt = 4'b0110; cyc("R10 perf pass");
    bpMatch = 4'hF; cyc("R9 match rise");
    cyc("R9 pulse");
    cyc("R9 held no repeat");
    cyc("R9 held no repeat");
    bpMatch = 4'h0; cyc("R9 match fall");
    bpMatch = 4'b0001; cyc("R9 second rise");
    cyc("R9 second pulse");
    bpMatch = 0; perfEvt = 4'b1111; cyc("R10 perf all");

    // R8: trace mode poisons
    wrCtrl(32'h41, "R8 trace on");
    event_(3'd1, 32'h1234_0000, 32'h5678_0000, "R8 branch in trace");
    readAll("R8 during trace");
    wrCtrl(32'h1, "R8 trace off");
    readAll("R8 poison kept");
    event_(3'd1, 32'hABCD_0000, 32'hEF01_0000, "R8 R3 capture after trace");
    readAll("R3 after trace");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule